// File: doc/BRIEF.md
# Sector Group Write-Protect Store

This block sits beside a flash array and remembers which sector groups are locked against modification. It keeps one sticky lock flag for each of 70 groups. A group is selected by the eight address bits 22 down to 15. A lock is written by a qualified write-strobe pulse that is only honoured while the elevated-voltage indicator on the A9 pin is active. That indicator is modelled here as an ordinary digital input.

The lock state can be read back on data bit 0 in two ways. The first is a verify read under elevated voltage. The second is an ordinary identification read at offset 02h inside the group's address range. The program and erase engines ask a separate query port whether a target group is locked, and the answer comes back in the same cycle. All bus pins are sampled on the rising clock edge, and edges on the write strobe are found by comparing it with its value in the previous cycle.

Top module: `sgprot_top`

## Requirements
- R1: After reset every group is unlocked: verify and identification reads return 0 and the query port reports no inhibit.
- R2: A lock is written by this sequence. First a cycle with `we_ni` low follows a cycle with it high. From that cycle until the first cycle with `we_ni` high, every sampled cycle must have `hv_a9_i`=1, `ce_ni`=0, `oe_ni`=0, address bits (A6,A3,A2,A1,A0)=(0,0,0,1,0) and the same group code. The group's flag is then set at the clock edge that samples `we_ni` high, and it is visible from the next cycle onward.
- R3: If the group code changes while the write strobe is low, the pulse is discarded and no flag changes.
- R4: If elevated voltage, chip enable, output enable or the low-address pattern drops out during the pulse, the pulse is discarded. A rising strobe with no qualified falling strobe before it changes nothing.
- R5: Verify read: in a cycle with `hv_a9_i`=1, `ce_ni`=0, `oe_ni`=0, `we_ni`=1 and the R2 low-address pattern, the next cycle shows `rd_vld_o`=1 and `rd_dq0_o` equal to the addressed group's flag.
- R6: When A1 is 0, no status is returned (`rd_vld_o`=0, `rd_dq0_o`=0). Those locations belong to the identification codes. Outside read cycles, `rd_dq0_o` is 0.
- R7: With `id_mode_i`=1, `ce_ni`=0, `oe_ni`=0, `we_ni`=1 and address bits 14 to 0 equal to 0x0002, the next cycle returns the addressed group's flag, whatever the state of `hv_a9_i`.
- R8: `inhibit_o` is high in the same cycle, combinationally, when `req_prog_i` or `req_erase_i` is high and the group `req_code_i` is locked.
- R9: Codes 70 to 255 name no group. They read back 0, cannot be locked, and never inhibit.
- R10: Locks are independent and sticky: setting one group leaves the others unchanged, and only reset clears a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hv_a9_i | input | 1 | Elevated voltage present on A9 |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| id_mode_i | input | 1 | Identification command has been accepted |
| addr_i | input | 23 | Decoded address A22..A0 |
| req_prog_i | input | 1 | Program request present |
| req_erase_i | input | 1 | Erase request present |
| req_code_i | input | 8 | Group code of the request |
| inhibit_o | output | 1 | Request targets a locked group |
| rd_vld_o | output | 1 | Status read-back cycle |
| rd_dq0_o | output | 1 | Lock flag on data bit 0 |

## Verification
A lock can complete at the same clock edge at which the same group is read back, or while it is being queried for inhibit. The read path registers the flag as it stood before that edge, so it still returns 0. The query port sees the new flag from the following cycle. The bench produces this overlap on purpose with directed sequences, and also lets random stimulus on a small set of group codes hit it often. A cycle-level reference model in the bench judges each cycle. The model updates its flags only after it has taken its read expectation.

// File: rtl/sgprot_pkg.sv
package sgprot_pkg;

    localparam int NGRP     = 70;
    localparam int CODE_W   = 8;
    localparam int ADDR_W   = 23;
    localparam int CODE_LSB = 15;
    localparam int IDX_W    = $clog2(NGRP);
    localparam int OFS_W    = CODE_LSB;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_st_e;

    // low-address pattern: A6=0, A3=0, A2=0, A1=1, A0=0
    function automatic logic lo_pattern_ok(input logic [ADDR_W-1:0] a);
        return (a[6] == 1'b0) && (a[3] == 1'b0) && (a[2] == 1'b0) &&
               (a[1] == 1'b1) && (a[0] == 1'b0);
    endfunction

    function automatic logic [CODE_W-1:0] grp_code(input logic [ADDR_W-1:0] a);
        return a[CODE_LSB +: CODE_W];
    endfunction

endpackage

// File: rtl/sgprot_grp_dec.sv
module sgprot_grp_dec
    import sgprot_pkg::*;
#(
    parameter int N_GROUPS = NGRP,
    parameter int C_W      = CODE_W,
    localparam int I_W     = $clog2(N_GROUPS)
) (
    input  logic [C_W-1:0] code_i,
    output logic [I_W-1:0] idx_o,
    output logic           valid_o
);

    always_comb begin
        valid_o = (32'(code_i) < 32'(N_GROUPS));
        idx_o   = valid_o ? code_i[I_W-1:0] : '0;
    end

endmodule

// File: rtl/sgprot_seq.sv
module sgprot_seq
    import sgprot_pkg::*;
#(
    parameter int C_W = CODE_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           we_ni,
    input  logic           qual_i,
    input  logic [C_W-1:0] code_i,
    output logic           set_o,
    output logic [C_W-1:0] set_code_o
);

    typedef struct packed {
        seq_st_e        st;
        logic [C_W-1:0] code;
        logic           we_prev;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        set_o      = 1'b0;
        set_code_o = r_q.code;
        r_d.we_prev = we_ni;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (r_q.we_prev && !we_ni && qual_i) begin
                    r_d.st   = SEQ_ARMED;
                    r_d.code = code_i;
                end
            end
            SEQ_ARMED: begin
                if (!qual_i || (code_i != r_q.code)) begin
                    r_d.st = SEQ_IDLE;
                end else if (we_ni) begin
                    set_o  = 1'b1;
                    r_d.st = SEQ_IDLE;
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st      <= SEQ_IDLE;
            r_q.code    <= '0;
            r_q.we_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/sgprot_bits.sv
module sgprot_bits
    import sgprot_pkg::*;
#(
    parameter int N_GROUPS = NGRP,
    localparam int I_W     = $clog2(N_GROUPS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                set_i,
    input  logic                set_valid_i,
    input  logic [I_W-1:0]      set_idx_i,
    input  logic [I_W-1:0]      rd_a_idx_i,
    input  logic                rd_a_valid_i,
    input  logic [I_W-1:0]      rd_b_idx_i,
    input  logic                rd_b_valid_i,
    output logic                rd_a_o,
    output logic                rd_b_o,
    output logic [N_GROUPS-1:0] bits_o
);

    logic [N_GROUPS-1:0] bits_d, bits_q;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_lock
        always_comb begin
            bits_d[g] = bits_q[g] |
                        (set_i && set_valid_i && (32'(set_idx_i) == g));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bits_q <= '0;
        else         bits_q <= bits_d;
    end

    always_comb begin
        rd_a_o = 1'b0;
        rd_b_o = 1'b0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (rd_a_valid_i && (32'(rd_a_idx_i) == g)) rd_a_o = bits_q[g];
            if (rd_b_valid_i && (32'(rd_b_idx_i) == g)) rd_b_o = bits_q[g];
        end
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/sgprot_rd.sv
module sgprot_rd
    import sgprot_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hv_i,
    input  logic              ce_ni,
    input  logic              oe_ni,
    input  logic              we_ni,
    input  logic              id_mode_i,
    input  logic              lo_ok_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              flag_i,
    output logic              vld_o,
    output logic              dq0_o
);

    typedef struct packed {
        logic vld;
        logic dq0;
    } rd_reg_t;

    rd_reg_t r_d, r_q;
    logic    bus_rd;
    logic    vfy_hit;
    logic    id_hit;

    always_comb begin
        bus_rd  = !ce_ni && !oe_ni && we_ni;
        vfy_hit = bus_rd && hv_i && lo_ok_i;
        id_hit  = bus_rd && id_mode_i && (ofs_i == OFS_W'(2));
        r_d.vld = vfy_hit || id_hit;
        r_d.dq0 = r_d.vld && flag_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign vld_o = r_q.vld;
    assign dq0_o = r_q.dq0;

endmodule

// File: rtl/sgprot_top.sv
module sgprot_top
    import sgprot_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hv_a9_i,
    input  logic              ce_ni,
    input  logic              oe_ni,
    input  logic              we_ni,
    input  logic              id_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              req_prog_i,
    input  logic              req_erase_i,
    input  logic [CODE_W-1:0] req_code_i,
    output logic              inhibit_o,
    output logic              rd_vld_o,
    output logic              rd_dq0_o
);

    logic              lo_ok;
    logic              qual;
    logic [CODE_W-1:0] bus_code;
    logic [IDX_W-1:0]  bus_idx;
    logic              bus_valid;
    logic [IDX_W-1:0]  req_idx;
    logic              req_valid;
    logic              set_en;
    logic [CODE_W-1:0] set_code;
    logic [IDX_W-1:0]  set_idx;
    logic              set_valid;
    logic              bus_flag;
    logic              req_flag;
    logic [NGRP-1:0]   prot_bits;

    always_comb begin
        lo_ok    = lo_pattern_ok(addr_i);
        bus_code = grp_code(addr_i);
        qual     = hv_a9_i && !ce_ni && !oe_ni && lo_ok;
    end

    sgprot_grp_dec #(.N_GROUPS(NGRP), .C_W(CODE_W)) u_dec_bus (
        .code_i (bus_code),
        .idx_o  (bus_idx),
        .valid_o(bus_valid)
    );

    sgprot_grp_dec #(.N_GROUPS(NGRP), .C_W(CODE_W)) u_dec_req (
        .code_i (req_code_i),
        .idx_o  (req_idx),
        .valid_o(req_valid)
    );

    sgprot_grp_dec #(.N_GROUPS(NGRP), .C_W(CODE_W)) u_dec_set (
        .code_i (set_code),
        .idx_o  (set_idx),
        .valid_o(set_valid)
    );

    sgprot_seq #(.C_W(CODE_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_ni     (we_ni),
        .qual_i    (qual),
        .code_i    (bus_code),
        .set_o     (set_en),
        .set_code_o(set_code)
    );

    sgprot_bits #(.N_GROUPS(NGRP)) u_bits (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_i       (set_en),
        .set_valid_i (set_valid),
        .set_idx_i   (set_idx),
        .rd_a_idx_i  (bus_idx),
        .rd_a_valid_i(bus_valid),
        .rd_b_idx_i  (req_idx),
        .rd_b_valid_i(req_valid),
        .rd_a_o      (bus_flag),
        .rd_b_o      (req_flag),
        .bits_o      (prot_bits)
    );

    sgprot_rd u_rd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hv_i     (hv_a9_i),
        .ce_ni    (ce_ni),
        .oe_ni    (oe_ni),
        .we_ni    (we_ni),
        .id_mode_i(id_mode_i),
        .lo_ok_i  (lo_ok),
        .ofs_i    (addr_i[OFS_W-1:0]),
        .flag_i   (bus_flag),
        .vld_o    (rd_vld_o),
        .dq0_o    (rd_dq0_o)
    );

    assign inhibit_o = (req_prog_i || req_erase_i) && req_flag;

endmodule

// File: rtl/sgprot_chk.sv
module sgprot_chk
    import sgprot_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ce_ni,
    input logic              oe_ni,
    input logic              we_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic [CODE_W-1:0] req_code_i,
    input logic              inhibit_o,
    input logic              rd_vld_o,
    input logic              rd_dq0_o,
    input logic [NGRP-1:0]   prot_bits
);

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (!rd_vld_o && !rd_dq0_o));

    assert_set_on_high_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_ni |=> $stable(prot_bits));

    assert_one_lock_per_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ($countones(prot_bits) <= $countones($past(prot_bits)) + 1));

    assert_a1_low_no_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && !oe_ni && we_ni && !addr_i[1]) |=> !rd_vld_o);

    assert_dq0_only_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_dq0_o |-> rd_vld_o);

    assert_unmapped_no_inhibit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(req_code_i) >= 32'(NGRP)) |-> !inhibit_o);

    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((prot_bits & $past(prot_bits)) == $past(prot_bits)));

endmodule

bind sgprot_top sgprot_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .oe_ni     (oe_ni),
    .we_ni     (we_ni),
    .addr_i    (addr_i),
    .req_code_i(req_code_i),
    .inhibit_o (inhibit_o),
    .rd_vld_o  (rd_vld_o),
    .rd_dq0_o  (rd_dq0_o),
    .prot_bits (prot_bits)
);

// File: tb/sgprot_tb.sv
module sgprot_top_tb_top;
    import sgprot_pkg::*;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              hv_a9_i = 1'b0;
    logic              ce_ni = 1'b1;
    logic              oe_ni = 1'b1;
    logic              we_ni = 1'b1;
    logic              id_mode_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              req_prog_i = 1'b0;
    logic              req_erase_i = 1'b0;
    logic [CODE_W-1:0] req_code_i = '0;
    logic              inhibit_o;
    logic              rd_vld_o;
    logic              rd_dq0_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [NGRP-1:0]   m_bits = '0;
    bit                m_armed = 1'b0;
    logic [CODE_W-1:0] m_code = '0;
    bit                m_prev = 1'b1;
    bit                e_vld = 1'b0;
    bit                e_dq = 1'b0;

    always #10 clk_i = ~clk_i;

    sgprot_top dut_i (.*);

    function automatic bit f_pat(input logic [ADDR_W-1:0] a);
        return !a[6] && !a[3] && !a[2] && a[1] && !a[0];
    endfunction

    function automatic bit f_flag(input logic [CODE_W-1:0] c);
        if (int'(c) >= NGRP) return 1'b0;
        return m_bits[c];
    endfunction

    function automatic logic [ADDR_W-1:0] f_addr(input logic [CODE_W-1:0] c,
                                                  input logic [14:0] lo);
        return {c, lo};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // one cycle: inputs set at negedge; inhibit checked now; model steps at posedge;
    // read path checked at the next negedge
    task automatic cyc(input bit hv, input bit ce, input bit oe, input bit we,
                       input bit id, input logic [ADDR_W-1:0] a,
                       input bit rp, input bit re, input logic [CODE_W-1:0] rc);
        bit q;
        bit vf;
        bit ih;
        string tg;
        hv_a9_i = hv; ce_ni = ce; oe_ni = oe; we_ni = we; id_mode_i = id;
        addr_i = a; req_prog_i = rp; req_erase_i = re; req_code_i = rc;
        #1;
        ih = (rp || re) && f_flag(rc);
        chk(inhibit_o == ih, (int'(rc) >= NGRP) ? "R9" : "R8", inhibit_o, ih);
        @(posedge clk_i);
        q  = hv && !ce && !oe && f_pat(a);
        vf = !ce && !oe && we && hv && f_pat(a);
        e_vld = vf || (!ce && !oe && we && id && (a[14:0] == 15'd2));
        e_dq  = e_vld && f_flag(a[22:15]);
        if (m_armed) begin
            if (!q || a[22:15] != m_code) m_armed = 1'b0;
            else if (we) begin
                if (int'(m_code) < NGRP) m_bits[m_code] = 1'b1;
                m_armed = 1'b0;
            end
        end else if (m_prev && !we && q) begin
            m_armed = 1'b1;
            m_code  = a[22:15];
        end
        m_prev = we;
        @(negedge clk_i);
        tg = vf ? "R5" : (e_vld ? "R7" : "R6");
        chk(rd_vld_o == e_vld, tg, rd_vld_o, e_vld);
        chk(rd_dq0_o == e_dq, tg, rd_dq0_o, e_dq);
    endtask

    localparam logic [14:0] PAT = 15'h0002;

    task automatic idle();
        cyc(0, 1, 1, 1, 0, '0, 0, 0, '0);
    endtask

    task automatic vread(input logic [CODE_W-1:0] c);
        cyc(1, 0, 0, 1, 0, f_addr(c, PAT), 0, 0, c);
    endtask

    task automatic protect(input logic [CODE_W-1:0] c);
        cyc(1, 0, 0, 1, 0, f_addr(c, PAT), 0, 0, '0);
        cyc(1, 0, 0, 0, 0, f_addr(c, PAT), 0, 0, '0);
        cyc(1, 0, 0, 0, 0, f_addr(c, PAT), 0, 0, '0);
        cyc(1, 0, 0, 1, 0, f_addr(c, PAT), 0, 0, '0);
    endtask

    initial begin
        int wd = 0;
        while (!done) begin
            @(posedge clk_i);
            wd++;
            if (wd > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [CODE_W-1:0] pool [8] = '{8'd3, 8'd5, 8'd9, 8'd40, 8'd69, 8'd70, 8'd72, 8'd200};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        // R1 reset state
        chk(rd_vld_o == 1'b0 && rd_dq0_o == 1'b0, "R1", rd_dq0_o, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        vread(8'd0); vread(8'd5); vread(8'd69);
        cyc(0, 1, 1, 1, 0, '0, 1, 1, 8'd5); // R1 no inhibit
        // R2 lock group 5; overlap: read same group in completion cycle
        protect(8'd5);
        vread(8'd5);
        chk(rd_dq0_o == 1'b1, "R2", rd_dq0_o, 1);
        // R10 neighbours untouched
        vread(8'd4); chk(rd_dq0_o == 1'b0, "R10", rd_dq0_o, 0);
        vread(8'd6); chk(rd_dq0_o == 1'b0, "R10", rd_dq0_o, 0);
        // R3 group code change mid-pulse
        cyc(1, 0, 0, 1, 0, f_addr(8'd9, PAT), 0, 0, '0);
        cyc(1, 0, 0, 0, 0, f_addr(8'd9, PAT), 0, 0, '0);
        cyc(1, 0, 0, 0, 0, f_addr(8'd10, PAT), 0, 0, '0);
        cyc(1, 0, 0, 1, 0, f_addr(8'd10, PAT), 0, 0, '0);
        vread(8'd9);  chk(rd_dq0_o == 1'b0, "R3", rd_dq0_o, 0);
        vread(8'd10); chk(rd_dq0_o == 1'b0, "R3", rd_dq0_o, 0);
        // R4 voltage drop mid-pulse
        cyc(1, 0, 0, 1, 0, f_addr(8'd11, PAT), 0, 0, '0);
        cyc(1, 0, 0, 0, 0, f_addr(8'd11, PAT), 0, 0, '0);
        cyc(0, 0, 0, 0, 0, f_addr(8'd11, PAT), 0, 0, '0);
        cyc(1, 0, 0, 1, 0, f_addr(8'd11, PAT), 0, 0, '0);
        vread(8'd11); chk(rd_dq0_o == 1'b0, "R4", rd_dq0_o, 0);
        // R4 rising strobe with no qualified fall (fall came with OE high)
        cyc(1, 0, 1, 1, 0, f_addr(8'd12, PAT), 0, 0, '0);
        cyc(1, 0, 1, 0, 0, f_addr(8'd12, PAT), 0, 0, '0);
        cyc(1, 0, 0, 0, 0, f_addr(8'd12, PAT), 0, 0, '0);
        cyc(1, 0, 0, 1, 0, f_addr(8'd12, PAT), 0, 0, '0);
        vread(8'd12); chk(rd_dq0_o == 1'b0, "R4", rd_dq0_o, 0);
        // R6 A1 low under verify conditions
        cyc(1, 0, 0, 1, 0, f_addr(8'd5, 15'h0000), 0, 0, '0);
        chk(rd_vld_o == 1'b0, "R6", rd_vld_o, 0);
        // R7 identification read, no elevated voltage
        cyc(0, 0, 0, 1, 1, f_addr(8'd5, 15'h0002), 0, 0, '0);
        chk(rd_dq0_o == 1'b1, "R7", rd_dq0_o, 1);
        cyc(0, 0, 0, 1, 1, f_addr(8'd5, 15'h0042), 0, 0, '0);
        chk(rd_vld_o == 1'b0, "R7", rd_vld_o, 0);
        // R8 inhibit for program and for erase
        cyc(0, 1, 1, 1, 0, '0, 1, 0, 8'd5);
        cyc(0, 1, 1, 1, 0, '0, 0, 1, 8'd5);
        cyc(0, 1, 1, 1, 0, '0, 0, 0, 8'd5);
        cyc(0, 1, 1, 1, 0, '0, 1, 1, 8'd6);
        // R9 unmapped code
        protect(8'd75);
        vread(8'd75); chk(rd_dq0_o == 1'b0, "R9", rd_dq0_o, 0);
        cyc(0, 1, 1, 1, 0, '0, 1, 1, 8'd75);
        // R8 overlap: lock 69 while querying it in the completion cycle
        cyc(1, 0, 0, 1, 0, f_addr(8'd69, PAT), 1, 0, 8'd69);
        cyc(1, 0, 0, 0, 0, f_addr(8'd69, PAT), 1, 0, 8'd69);
        cyc(1, 0, 0, 1, 0, f_addr(8'd69, PAT), 1, 0, 8'd69);
        cyc(0, 1, 1, 1, 0, '0, 1, 0, 8'd69);
        idle();
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [CODE_W-1:0] c;
            logic [14:0] lo;
            int r;
            c  = pool[$urandom % 8];
            r  = $urandom % 8;
            lo = (r < 5) ? (PAT | 15'($urandom & 32'h30)) :
                 (r < 6) ? 15'h0002 : 15'($urandom);
            cyc(($urandom % 8) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                ($urandom % 3) != 0, ($urandom % 4) == 0, f_addr(c, lo),
                ($urandom % 2) == 0, ($urandom % 2) == 0, pool[$urandom % 8]);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule